// File: doc/BRIEF.md
# Search-Mode Envelope Qualifier and Tape Speed Meter

During fast winding the read path delivers a single sliced envelope bit taken from the auxiliary track. This block watches that bit and raises one of two status flags. A label flag rises when the envelope has held high for long enough, and a blank-tape flag rises when it has held low for long enough. Both qualification windows are measured in auxiliary block lengths, using a one-cycle block tick supplied from outside. Each flag stays where it is until a run of the opposite level has also qualified, which gives the flags hysteresis.

The same envelope also gives the tape speed. The block counts prescaled ticks between consecutive rising edges of the envelope and reports the result as a 5-bit period count plus a 2-bit range. Each step up in range doubles the prescaled tick rate. The range moves by itself so that the count stays inside a useful band. The speed in multiples of normal is 51.2 × 2^range / count. An invalid flag tells the reader to ignore the count and range fields. Outside search mode, every output sits in a quiet state.

Top module: `search_env_monitor`

## Requirements
- R1: When `mode` is not 2'b10 (search; 2'b00 normal, 2'b01 test, 2'b11 off), the block forces its outputs one cycle later as follows: `env_out`, `label_flag` and `blank_flag` go low, `spd_cnt` and `spd_rng` go to 0, and `spd_bad` goes high. The qualification run and the speed state restart.
- R2: In search mode, `env_out` equals `env_in` delayed by one clock.
- R3: After `env_in` has been high for QUAL_BLOCKS (8) counted `blk_tick` pulses with no break, `label_flag` sets and `blank_flag` clears. Any level change restarts the run. A tick that falls in the same cycle as a level change is not counted.
- R4: After a low run of 8 counted ticks, `blank_flag` sets and `label_flag` clears. A shorter run of either level leaves both flags unchanged. The two flags are never high together.
- R5: At each rising edge of the envelope in search mode, the period since the previous rising edge is published. If that period is P clocks, `spd_cnt` = floor(P / (PRE_BASE >> range)), where PRE_BASE = 16 and range is the range that applied during that period. `spd_rng` reports that same range. The first rising edge after entering search starts a period but publishes nothing.
- R6: When a period reaches 32 or more ticks, the published count is 0, `spd_bad` is set, and the range steps down by one if it is above 0.
- R7: A published count of 1 or less steps the range up by one, up to 3. A count of 18 or more steps it down by one, down to 0. Counts from 2 to 17 leave the range unchanged. A new range applies from the period that begins at that same edge.
- R8: The first count published after a range change is marked invalid (`spd_bad` = 1). The count after that is valid if nothing else marks it.
- R9: If no rising edge of the envelope arrives within 32 × PRE_BASE clocks (512), `spd_bad` is set.
- R10: `spd_bad` is high whenever `label_flag` is low.
- R11: After a synchronous reset (`rst_n` low at a clock edge): both flags and `env_out` are low, `spd_cnt` and `spd_rng` are 0, and `spd_bad` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Operating mode; 2'b10 selects search |
| env_in | input | 1 | Sliced envelope of the auxiliary track |
| blk_tick | input | 1 | One-cycle pulse once per auxiliary block length |
| env_out | output | 1 | Registered envelope, low outside search |
| label_flag | output | 1 | Long continuous high qualified |
| blank_flag | output | 1 | Long continuous low qualified |
| spd_cnt | output | 5 | Period count in prescaled ticks |
| spd_rng | output | 2 | Range the count was measured in |
| spd_bad | output | 1 | Count and range must be ignored when high |

## Verification
The assertions assume that `env_in`, `mode` and `blk_tick` are synchronous to `clk`. They also assume that PRE_BASE shifted right by the top range still leaves a prescale of at least two clocks, which keeps the prescaler's phase inside its span after every range switch. The bench changes every input on the falling clock edge. It drives envelope periods from 2 to 300 clocks, which keeps each period below the 512-clock timeout except in the timeout and overflow cases, where that is the intent. It gives block ticks as isolated single-cycle pulses and never gives them during the speed sweep, so the label flag stays steady while range shifts are checked.

// File: rtl/srch_pkg.sv
// Shared definitions for the search-mode envelope monitor.
// Assumes: the mode code is a 2-bit field decoded by the top level.
package srch_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SEARCH = 2'b10,
        MODE_OFF    = 2'b11
    } op_mode_e;
endpackage

// File: rtl/srch_level_qual.sv
// Level qualifier: counts block ticks over a run of constant envelope level
// and sets the label or blank flag once the run reaches QUAL_BLOCKS ticks.
// Assumes: env_in and blk_tick are synchronous; active low clears all state.
module srch_level_qual #(
    parameter int QUAL_BLOCKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic env_in,
    input  logic blk_tick,
    output logic env_o,
    output logic label_o,
    output logic blank_o
);
    localparam int RUN_W = $clog2(QUAL_BLOCKS + 1);
    localparam logic [RUN_W-1:0] QUAL_C = RUN_W'(QUAL_BLOCKS);

    logic             run_lvl;
    logic [RUN_W-1:0] run_cnt;

    // Track the current run level and count block ticks within it.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            run_lvl <= 1'b0;
            run_cnt <= '0;
        end else if (env_in != run_lvl) begin
            run_lvl <= env_in;
            run_cnt <= '0;
        end else if (blk_tick && run_cnt != QUAL_C) begin
            run_cnt <= run_cnt + RUN_W'(1);
        end
    end

    // Update the flags once a run has qualified; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            label_o <= 1'b0;
            blank_o <= 1'b0;
        end else if (run_cnt == QUAL_C) begin
            label_o <= run_lvl;
            blank_o <= !run_lvl;
        end
    end

    // Register the envelope for output, forced low outside search.
    always_ff @(posedge clk) begin
        if (!rst_n) env_o <= 1'b0;
        else        env_o <= active && env_in;
    end

    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!label_o && !blank_o && !env_o))
        else $error("flags not forced low outside search");
    assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= QUAL_C)
        else $error("run counter beyond qualification limit");
    assert_label_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(label_o) |-> $past(run_lvl))
        else $error("label rose without a high run");
    assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(label_o && blank_o))
        else $error("label and blank high together");
endmodule

// File: rtl/srch_tick_gen.sv
// Range-scaled prescaler: emits one tick every (PRE_BASE >> rng) clocks,
// phase-aligned so a period of P clocks yields floor(P/div) ticks.
// Assumes: PRE_BASE is a power of two and PRE_BASE >> (2**RNG_W-1) >= 2.
module srch_tick_gen #(
    parameter int PRE_BASE = 16,
    parameter int RNG_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [RNG_W-1:0] rng,
    output logic             tick_o
);
    localparam int PRE_W = $clog2(PRE_BASE);
    localparam logic [PRE_W:0] BASE_C = (PRE_W+1)'(PRE_BASE);

    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] last_c;
    logic [PRE_W-1:0] pre_cnt;

    // Derive the last phase value of the current prescale span.
    always_comb begin
        span   = BASE_C >> rng;
        last_c = PRE_W'(span - (PRE_W+1)'(1));
    end

    assign tick_o = !clr && (pre_cnt == last_c);

    // Advance the prescaler phase; restart at phase 1 on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        pre_cnt <= PRE_W'(1);
        else if (pre_cnt == last_c) pre_cnt <= '0;
        else                      pre_cnt <= pre_cnt + PRE_W'(1);
    end

    assert_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= last_c)
        else $error("prescaler phase outside its span");
endmodule

// File: rtl/srch_speed_meter.sv
// Speed meter: counts prescaled ticks per envelope period, publishes the
// count with its range at each rising edge, steps the range, and marks
// results invalid after a range change, on overflow, timeout or no label.
// Assumes: edge_i is a single-cycle pulse on envelope rising edges.
module srch_speed_meter #(
    parameter int PRE_BASE = 16,
    parameter int CNT_W    = 5,
    parameter int RNG_W    = 2,
    parameter int UP_AT    = 1,
    parameter int DOWN_AT  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             edge_i,
    input  logic             tick_i,
    input  logic             label_i,
    output logic [RNG_W-1:0] rng_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [RNG_W-1:0] rng_rep_o,
    output logic             bad_o
);
    localparam int CNT_MAX = 2 ** CNT_W;
    localparam int TMO     = CNT_MAX * PRE_BASE;
    localparam int TMO_W   = $clog2(TMO + 1);
    localparam logic [CNT_W:0]   MAX_C  = (CNT_W+1)'(CNT_MAX);
    localparam logic [CNT_W:0]   UP_C   = (CNT_W+1)'(UP_AT);
    localparam logic [CNT_W:0]   DN_C   = (CNT_W+1)'(DOWN_AT);
    localparam logic [TMO_W-1:0] TMO_C  = TMO_W'(TMO);
    localparam logic [RNG_W-1:0] TOP_C  = RNG_W'(2 ** RNG_W - 1);

    logic [CNT_W:0]   tick_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic [RNG_W-1:0] rng_cur, rng_nxt;
    logic             have_start, chg_pend, meas_bad;
    logic             ovf, go_up, go_dn;

    // Decide the range step from the period that is ending.
    always_comb begin
        ovf     = tick_cnt[CNT_W];
        go_up   = !ovf && (tick_cnt <= UP_C) && (rng_cur != TOP_C);
        go_dn   = (ovf || tick_cnt >= DN_C) && (rng_cur != '0);
        rng_nxt = go_up ? rng_cur + RNG_W'(1) :
                  go_dn ? rng_cur - RNG_W'(1) : rng_cur;
    end

    // Measure, publish and step the range at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tick_cnt   <= '0;
            tmo_cnt    <= '0;
            rng_cur    <= '0;
            have_start <= 1'b0;
            chg_pend   <= 1'b0;
            meas_bad   <= 1'b1;
            cnt_o      <= '0;
            rng_rep_o  <= '0;
        end else if (edge_i) begin
            tick_cnt   <= '0;
            tmo_cnt    <= '0;
            have_start <= 1'b1;
            if (have_start) begin
                cnt_o     <= ovf ? '0 : tick_cnt[CNT_W-1:0];
                rng_rep_o <= rng_cur;
                meas_bad  <= chg_pend || ovf;
                rng_cur   <= rng_nxt;
                chg_pend  <= go_up || go_dn;
            end
        end else begin
            if (tick_i && !ovf) tick_cnt <= tick_cnt + (CNT_W+1)'(1);
            if (tmo_cnt != TMO_C) tmo_cnt <= tmo_cnt + TMO_W'(1);
            else                  meas_bad <= 1'b1;
        end
    end

    assign rng_o = rng_cur;
    assign bad_o = meas_bad || !label_i;

    assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= MAX_C)
        else $error("tick counter beyond saturation");
    assert_ovf_pub_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && edge_i && have_start && ovf) |=> (cnt_o == '0 && meas_bad))
        else $error("overflow not published as invalid zero");
    assert_rng_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rng_cur) |-> ($past(edge_i) || !$past(active)))
        else $error("range moved away from a period boundary");
    assert_chg_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && edge_i && have_start && chg_pend) |=> meas_bad)
        else $error("first result after range change not invalid");
    assert_tmo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !edge_i && tmo_cnt == TMO_C) |=> bad_o)
        else $error("timeout did not invalidate speed");
endmodule

// File: rtl/search_env_monitor.sv
// Search-mode envelope monitor: label/blank qualification and auto-ranging
// tape speed measurement from the sliced auxiliary envelope.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous.
module search_env_monitor
    import srch_pkg::*;
#(
    parameter int QUAL_BLOCKS = 8,
    parameter int PRE_BASE    = 16,
    parameter int CNT_W       = 5,
    parameter int RNG_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             env_in,
    input  logic             blk_tick,
    output logic             env_out,
    output logic             label_flag,
    output logic             blank_flag,
    output logic [CNT_W-1:0] spd_cnt,
    output logic [RNG_W-1:0] spd_rng,
    output logic             spd_bad
);
    logic             in_search;
    logic             env_prev;
    logic             rise;
    logic             tick;
    logic [RNG_W-1:0] rng_now;

    assign in_search = (mode == MODE_SEARCH);
    assign rise      = in_search && env_in && !env_prev;

    // Remember the previous envelope level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) env_prev <= 1'b0;
        else        env_prev <= env_in;
    end

    srch_level_qual #(.QUAL_BLOCKS(QUAL_BLOCKS)) qual_i (
        .clk(clk), .rst_n(rst_n), .active(in_search), .env_in(env_in),
        .blk_tick(blk_tick), .env_o(env_out), .label_o(label_flag),
        .blank_o(blank_flag)
    );

    srch_tick_gen #(.PRE_BASE(PRE_BASE), .RNG_W(RNG_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .clr(rise || !in_search), .rng(rng_now),
        .tick_o(tick)
    );

    srch_speed_meter #(.PRE_BASE(PRE_BASE), .CNT_W(CNT_W), .RNG_W(RNG_W)) spd_i (
        .clk(clk), .rst_n(rst_n), .active(in_search), .edge_i(rise),
        .tick_i(tick), .label_i(label_flag), .rng_o(rng_now),
        .cnt_o(spd_cnt), .rng_rep_o(spd_rng), .bad_o(spd_bad)
    );

    assert_off_speed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_search |=> (spd_bad && spd_cnt == '0 && spd_rng == '0))
        else $error("speed word not quiet outside search");
    assert_no_label_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !label_flag |-> spd_bad)
        else $error("speed valid without label");
endmodule

// File: tb/search_env_monitor_tb_top.sv
`timescale 1ns/1ps
module search_env_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       env_in = 1'b0;
    logic       blk_tick = 1'b0;
    logic       env_out, label_flag, blank_flag, spd_bad;
    logic [4:0] spd_cnt;
    logic [1:0] spd_rng;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    search_env_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .env_in(env_in),
        .blk_tick(blk_tick), .env_out(env_out), .label_flag(label_flag),
        .blank_flag(blank_flag), .spd_cnt(spd_cnt), .spd_rng(spd_rng),
        .spd_bad(spd_bad)
    );

    // Speed sweep: period, period count, then expected count/range/invalid.
    localparam int NV = 8;
    localparam int V_P  [NV] = '{160, 24, 8, 4, 2, 40, 300, 200};
    localparam int V_N  [NV] = '{3,   4,  4, 4, 3, 3,  3,   3};
    localparam int V_CNT[NV] = '{10,  3,  2, 2, 1, 10, 0,   12};
    localparam int V_RNG[NV] = '{0,   1,  2, 3, 3, 2,  1,   0};
    localparam int V_BAD[NV] = '{0,   0,  0, 0, 0, 1,  1,   0};

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            blk_tick = 1'b1; @(negedge clk);
            blk_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic periods(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            env_in = 1'b1; repeat (p / 2) @(negedge clk);
            env_in = 1'b0; repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 label", label_flag, 0);
        chk("R11 blank", blank_flag, 0);
        chk("R11 env_out", env_out, 0);
        chk("R11 spd_cnt", spd_cnt, 0);
        chk("R11 spd_bad", spd_bad, 1);

        // R1 normal mode ignores a long high
        env_in = 1'b1;
        ticks(10);
        chk("R1 label normal", label_flag, 0);
        chk("R1 env_out normal", env_out, 0);

        // R2/R3 search: env follows, label after 8 ticks only
        mode = 2'b10;
        @(negedge clk);
        chk("R2 env_out high", env_out, 1);
        ticks(7);
        chk("R3 label after 7", label_flag, 0);
        chk("R10 bad no label", spd_bad, 1);
        ticks(1);
        chk("R3 label after 8", label_flag, 1);
        chk("R3 blank after label", blank_flag, 0);

        // R4 low run: hysteresis, then blank
        env_in = 1'b0;
        @(negedge clk);
        chk("R2 env_out low", env_out, 0);
        ticks(7);
        chk("R4 label held", label_flag, 1);
        chk("R4 blank after 7", blank_flag, 0);
        ticks(1);
        chk("R4 blank after 8", blank_flag, 1);
        chk("R4 label cleared", label_flag, 0);

        // R3 run restarts on a one-cycle break
        env_in = 1'b1; @(negedge clk);
        ticks(5);
        env_in = 1'b0; @(negedge clk);
        env_in = 1'b1; @(negedge clk);
        ticks(5);
        chk("R3 broken run label", label_flag, 0);
        chk("R3 broken run blank", blank_flag, 1);
        ticks(3);
        chk("R3 restarted run label", label_flag, 1);

        // R1 off mode clears everything
        mode = 2'b11; env_in = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 label off", label_flag, 0);
        chk("R1 blank off", blank_flag, 0);
        chk("R1 env_out off", env_out, 0);
        chk("R1 spd_bad off", spd_bad, 1);
        chk("R1 spd_rng off", spd_rng, 0);

        // Speed sweep under a qualified label
        mode = 2'b10; env_in = 1'b1;
        @(negedge clk);
        ticks(8);
        chk("R3 label for sweep", label_flag, 1);
        env_in = 1'b0;
        repeat (600) @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            periods(V_P[v], V_N[v]);
            // R5 count, R7 range, R6/R8 invalid
            chk($sformatf("R5 cnt vec%0d", v), spd_cnt, V_CNT[v]);
            chk($sformatf("R7 rng vec%0d", v), spd_rng, V_RNG[v]);
            chk($sformatf("R8 bad vec%0d", v), spd_bad, V_BAD[v]);
        end

        // R10 label loss invalidates a good measurement
        ticks(8);
        chk("R10 label dropped", label_flag, 0);
        chk("R10 bad without label", spd_bad, 1);
        env_in = 1'b1; @(negedge clk);
        ticks(8);
        chk("R10 label back", label_flag, 1);
        chk("R10 bad with label", spd_bad, 0);

        // R9 timeout with no rising edge
        repeat (400) @(negedge clk);
        chk("R9 before timeout", spd_bad, 0);
        repeat (200) @(negedge clk);
        chk("R9 after timeout", spd_bad, 1);

        finish_run();
    end
endmodule